// File: doc/BRIEF.md
# Dual-Edge Serial-to-Parallel Word Assembler

This block takes one serial data line that carries a new bit on every edge of its bit clock, rising and falling alike, and turns the stream into 12-bit parallel words. The line is sampled on each clock edge by a single flop, one flop per edge. After each of those flops comes a 6-bit shift register clocked on the rising edge. On every sixth rising edge, the two 6-bit halves are woven together into one word. The word goes into a parallel holding register, and a one-cycle strobe marks it as fresh.

Word framing uses a plain slip control. Hold the slip input high on a rising edge and the framing counter pauses for that edge. The word boundary then moves two bit positions later in the serial stream. Logic upstream can pulse slip until the words it sees line up with a known pattern. The half width is a parameter, so the word width is always twice the number of bits captured on each edge.

Top module: `ddr_deser`

## Requirements
- R1: When `rst` is high at a rising edge, the next cycle shows `word` as all zeros and `valid` low. The capture flops, the shift registers and the framing counter are cleared as well. After `rst` is released, the first strobe comes on the sixth rising edge, and its word holds zeros in every bit pair that was received before the release.
- R2: If `slip` is never asserted, `valid` is high for exactly one cycle in every six. Two cycles in a row never both carry `valid`.
- R3: Number the bits of a strobed word from bit 11 down to bit 0. The word is built from the six clock cycles that end one cycle before the loading edge. Bit 11 is the rising-edge bit of the earliest of those cycles and bit 10 is its falling-edge bit. Each later cycle takes the next lower pair, so bit 1 is the rising-edge bit of the latest cycle and bit 0 is its falling-edge bit.
- R4: `word` does not change in any cycle in which `valid` is low.
- R5: A high `slip` at a rising edge pauses the framing for that edge, so no word can be loaded on it. Every later strobe comes one cycle later, and each word then starts two serial bits later in the stream.
- R6: The level on `sdata` just before a falling edge is what appears in the odd positions of the word (bit 10, bit 8, …). The level just before the rising edge that opens the same cycle is what appears in the even positions beside it (bit 11, bit 9, …).
- R7: The half width `HALF_W` must be at least 2. `word` is `2*HALF_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data is sampled on both edges |
| rst | input | 1 | Synchronous reset, active high |
| sdata | input | 1 | Serial data line, one bit per clock edge |
| slip | input | 1 | Pauses the framing counter for one rising edge |
| word | output | 2*HALF_W | Assembled parallel word |
| valid | output | 1 | High for one cycle when `word` has just been loaded |

## Verification
A bit pair is on the line during clock cycle k: the even bit before the rising edge, the odd bit before the falling edge. That pair enters the shift registers at rising edge k+1. The holding register and `valid` change at that same edge when the framing counter wraps on it. The result is therefore seen in the cycle that follows edge k+1. A slip or a reset applied at an edge shows its effect in the cycle right after that edge.

The bench drives the even bit a quarter period before each rising edge and the odd bit a quarter period before each falling edge. It reads `word` and `valid` a quarter period after the falling edge and compares them with a queue-based model that is stepped at each rising edge. No sample is ever taken near the edge at which the value changes.

// File: rtl/ddr_deser_pkg.sv
package ddr_deser_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_e;

   localparam int unsigned LANES = 2;

   function automatic edge_e lane_edge(input int unsigned lane);
      return (lane == 0) ? EDGE_RISE : EDGE_FALL;
   endfunction

endpackage

// File: rtl/ddr_deser_capture.sv
module ddr_deser_capture
   import ddr_deser_pkg::*;
#(
   parameter edge_e EDGE = EDGE_RISE
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic q
);

   generate
      if (EDGE == EDGE_RISE) begin : g_rise
         always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
      end else begin : g_fall
         always_ff @(negedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= din;
         end
      end
   endgenerate

endmodule

// File: rtl/ddr_deser_shifter.sv
module ddr_deser_shifter #(
   parameter int unsigned WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bit_in,
   output logic [WIDTH-1:0] sr_next
);

   logic [WIDTH-1:0] sr_q;

   // newest bit enters at the bottom, oldest sits at the top
   always_comb sr_next = {sr_q[WIDTH-2:0], bit_in};

   always_ff @(posedge clk) begin
      if (rst) sr_q <= '0;
      else     sr_q <= sr_next;
   end

endmodule

// File: rtl/ddr_deser_framer.sv
module ddr_deser_framer #(
   parameter int unsigned HALF_W = 6,
   localparam int unsigned WORD_W = 2 * HALF_W,
   localparam int unsigned CNT_W  = (HALF_W > 1) ? $clog2(HALF_W) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slip,
   input  logic [HALF_W-1:0] rise_bits,
   input  logic [HALF_W-1:0] fall_bits,
   output logic [WORD_W-1:0] word,
   output logic              valid
);

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic              wrap;
   logic [WORD_W-1:0] woven;

   // pair i (oldest first) lands in the two bits just below pair i-1
   generate
      for (genvar i = 0; i < HALF_W; i++) begin : g_weave
         assign woven[WORD_W-1-2*i] = rise_bits[HALF_W-1-i];
         assign woven[WORD_W-2-2*i] = fall_bits[HALF_W-1-i];
      end
   endgenerate

   always_comb wrap = !slip && (cnt_q == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (!slip) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         word  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= wrap;
         if (wrap) word <= woven;
      end
   end

endmodule

// File: rtl/ddr_deser.sv
module ddr_deser
   import ddr_deser_pkg::*;
#(
   parameter int unsigned HALF_W = 6,
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sdata,
   input  logic              slip,
   output logic [WORD_W-1:0] word,
   output logic              valid
);

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("ddr_deser: HALF_W must be at least 2 (R7)");
      end
   endgenerate

   logic              cap   [LANES];
   logic [HALF_W-1:0] shnext[LANES];

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         ddr_deser_capture #(
            .EDGE(lane_edge(g))
         ) u_cap (
            .clk (clk),
            .rst (rst),
            .din (sdata),
            .q   (cap[g])
         );

         ddr_deser_shifter #(
            .WIDTH(HALF_W)
         ) u_sh (
            .clk     (clk),
            .rst     (rst),
            .bit_in  (cap[g]),
            .sr_next (shnext[g])
         );
      end
   endgenerate

   ddr_deser_framer #(
      .HALF_W(HALF_W)
   ) u_frame (
      .clk       (clk),
      .rst       (rst),
      .slip      (slip),
      .rise_bits (shnext[0]),
      .fall_bits (shnext[1]),
      .word      (word),
      .valid     (valid)
   );

endmodule

// File: rtl/ddr_deser_chk.sv
module ddr_deser_chk #(
   parameter int unsigned HALF_W = 6,
   localparam int unsigned WORD_W = 2 * HALF_W
) (
   input logic              clk,
   input logic              rst,
   input logic              slip,
   input logic [WORD_W-1:0] word,
   input logic              valid
);

   logic live_q;
   logic armed;

   always_ff @(posedge clk) begin
      if (rst) live_q <= 1'b1;
   end

   always_comb armed = (live_q === 1'b1);

   // R1: one reset edge leaves outputs cleared
   p_reset_clear_r1: assert property (@(posedge clk)
      (armed && $past(rst)) |-> (word == '0 && !valid));

   // R2: strobe never lasts two cycles
   p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
      (armed && valid) |=> !valid);

   // R4: word held between strobes
   p_hold_word_r4: assert property (@(posedge clk) disable iff (rst)
      (armed && !valid) |-> $stable(word));

   // R5: no load on an edge where slip was high
   p_slip_blocks_r5: assert property (@(posedge clk) disable iff (rst)
      (armed && valid) |-> !$past(slip));

endmodule

bind ddr_deser ddr_deser_chk #(.HALF_W(HALF_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .slip  (slip),
   .word  (word),
   .valid (valid)
);

// File: tb/ddr_deser_bench.sv
module ddr_deser_bench;

   localparam int HW = 6;
   localparam int WW = 2 * HW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sdata = 1'b0;
   logic          slip = 1'b0;
   logic [WW-1:0] word;
   logic          valid;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   ddr_deser #(.HALF_W(HW)) u_ddr_deser (
      .clk   (clk),
      .rst   (rst),
      .sdata (sdata),
      .slip  (slip),
      .word  (word),
      .valid (valid)
   );

   // behavioural model state
   bit            hr[$];
   bit            hf[$];
   int            mcnt = 0;
   bit            prev_r = 0, prev_f = 0;
   logic [WW-1:0] exp_word = '0;
   bit            exp_valid = 0;
   string         tag = "R1";

   task automatic check(input string req, input logic [WW-1:0] act_w, input logic act_v,
                        input logic [WW-1:0] e_w, input bit e_v);
      total++;
      if (act_w !== e_w || act_v !== e_v) begin
         bad++;
         $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b at %0t",
                  req, act_w, act_v, e_w, e_v, $time);
      end
   endtask

   task automatic model_reset();
      hr.delete(); hf.delete();
      for (int i = 0; i < HW; i++) begin hr.push_back(0); hf.push_back(0); end
      mcnt = 0; exp_word = '0; exp_valid = 0;
   endtask

   task automatic model_step(input bit r_in, input bit s_in);
      if (r_in) begin
         model_reset();
         tag = "R1";
         return;
      end
      hr.push_back(prev_r); hf.push_back(prev_f);
      if (s_in) begin
         exp_valid = 0;
         tag = "R5";
      end else if (mcnt == HW - 1) begin
         mcnt = 0;
         for (int i = 0; i < HW; i++) begin
            exp_word[WW-1-2*i] = hr[hr.size()-HW+i];
            exp_word[WW-2-2*i] = hf[hf.size()-HW+i];
         end
         exp_valid = 1;
         tag = "R3";
      end else begin
         mcnt++;
         exp_valid = 0;
         tag = "R4";
      end
   endtask

   // one bit-clock cycle: even bit r, odd bit f
   task automatic cyc(input bit r, input bit f, input bit s, input bit rs);
      @(negedge clk); #5;
      check(tag, word, valid, exp_word, exp_valid);
      sdata = r; slip = s; rst = rs;
      @(posedge clk);
      model_step(rs, s);
      #5 sdata = f;
      if (rs) begin prev_r = 0; prev_f = 0; end
      else    begin prev_r = r; prev_f = f; end
   endtask

   task automatic send_word(input logic [WW-1:0] w);
      for (int i = 0; i < HW; i++) cyc(w[WW-1-2*i], w[WW-2-2*i], 1'b0, 1'b0);
   endtask

   task automatic do_reset();
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b0, 1'b1);
   endtask

   initial begin
      model_reset();
      do_reset();
      // R1: first strobe after release carries zeros from before release
      cyc(1,0,0,0); cyc(0,1,0,0); cyc(1,1,0,0);
      cyc(0,0,0,0); cyc(1,0,0,0); cyc(0,1,0,0);
      // R2, R3, R6: aligned words of varied patterns
      send_word(12'hA5C);
      send_word(12'hFFF);
      send_word(12'h555);   // odd-edge bits only
      send_word(12'hAAA);   // even-edge bits only
      send_word(12'h801);
      send_word(12'h000);
      // R5: single slip, then a double slip
      cyc(1,1,1,0);
      send_word(12'h3C6);
      send_word(12'h9E1);
      cyc(0,1,1,0); cyc(1,0,1,0);
      for (int k = 0; k < 4; k++) send_word(12'(k * 397 + 5));
      // R1: reset in mid-word
      cyc(1,1,0,0); cyc(0,1,0,0);
      do_reset();
      send_word(12'hB2D);
      send_word(12'h147);
      cyc(0,0,0,0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      done = 1;
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule